// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode-Mapped Entry

This block is the control sequencer of a small microprogrammed processor. It keeps an 11-bit micro-program counter and a 24-bit control store written as combinational case logic. The microword at the current micro-address appears on the output in the same cycle. At every clock edge the sequencer picks the next micro-address. It has four ways to do this: step by one, take the microword's next-address field, map the instruction opcode to an entry point, or branch on a flag.

Every instruction owns a 32-word slot in the store. The entry address is built from three parts: the two top bits of the fetch microword's next-address field, the 4-bit opcode, and five zero bits. The fetch word names 600h, so the entries run from 600h to 7E0h. The opcode is taken from the instruction bus nibble while the fetch word is current. The zero and carry flags matter only in the test word of the two conditional-jump routines. The datapath that consumes the control bits is not part of this block.

Top module: `mseq_core`

## Requirements
- R1: An active-low asynchronous reset puts the micro-address at 000h at once. The microword shown at 000h has its instruction-load strobe `uword_o[0]` low.
- R2: Micro-address 000h is followed by 001h, the fetch word.
- R3: While the micro-address is 001h, the value of `ir_op_i` at the next clock edge selects the next micro-address. That address is the opcode times 32 plus the base.
- R4: The base comes from bits 10:9 of the fetch word's next-address field. Those bits are 11, so the entries run 600h, 620h, and so on up to 7E0h. Bits 4:0 of every entry are zero.
- R5: Routines other than the conditional jumps and stop step by one and then return to 001h after their last word. Slot lengths by opcode are: 0:2, 1:1, 2:4, 3:4, 4:3, 8:3, 9:3, A:3, B:2, C:2, D:2, E:2, F:1.
- R6: The zero-flag jump (opcode 5) runs slot offsets 0, 1, 2. At offset 2 it goes to offset 5 if `zero_i` is 1 and to offset 4 if it is 0. Either of those words then returns to 001h. `carry_i` has no effect here.
- R7: The carry-flag jump (opcode 6) follows the same pattern as R6, testing `carry_i`. `zero_i` has no effect here.
- R8: The stop routine (opcode 7) cycles 6E0h, 6E1h, 6E0h, ... and never returns to fetch, whatever the inputs do.
- R9: Outside the fetch word, `ir_op_i` has no effect. Outside the two test words, the flags have no effect.
- R10: `uword_o` shows the word at the current micro-address in the same cycle. Its bit 0, the instruction-load strobe, is 1 exactly when the micro-address is 001h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_op_i | input | 4 | Opcode nibble on the instruction bus, sampled during fetch |
| zero_i | input | 1 | Zero flag |
| carry_i | input | 1 | Carry flag |
| uword_o | output | 24 | Microword at the current micro-address |
| upc_o | output | 11 | Current micro-address |

## Verification
Every next-address decision is registered once. An opcode or flag that is present while the deciding word is current shows up in `upc_o` one edge later. `uword_o` follows `upc_o` in the same cycle. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares both outputs on the following falling edge, so each result is sampled exactly one register stage after the stimulus that caused it. Between decisions, the opcode and flag inputs are driven with changing noise to expose any influence they should not have.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int UPC_W  = 11;
  localparam int OP_W   = 4;
  localparam int SLOT_W = 5;
  localparam int BASE_W = UPC_W - OP_W - SLOT_W;
  localparam int CTRL_W = 10;
  localparam int MODE_W = 3;
  localparam int WORD_W = MODE_W + UPC_W + CTRL_W;

  localparam logic [UPC_W-1:0] IDLE_ADDR  = 11'h000;
  localparam logic [UPC_W-1:0] FETCH_ADDR = 11'h001;
  localparam logic [UPC_W-1:0] MAP_BASE   = 11'h600;

  typedef enum logic [MODE_W-1:0] {
    SEQ_INC  = 3'd0,
    SEQ_JMP  = 3'd1,
    SEQ_MAP  = 3'd2,
    SEQ_TSTZ = 3'd3,
    SEQ_TSTC = 3'd4
  } seq_mode_e;

  typedef struct packed {
    logic [2:0] alu_fn;
    logic       flag_wr;
    logic       reg_wr;
    logic       mem_wr;
    logic       mem_rd;
    logic       ar_load;
    logic       pc_inc;
    logic       ir_load;
  } ctrl_t;

  typedef struct packed {
    seq_mode_e        mode;
    logic [UPC_W-1:0] nxt;
    ctrl_t            ctrl;
  } uword_t;

  function automatic uword_t mk(seq_mode_e m, logic [UPC_W-1:0] n, logic [CTRL_W-1:0] c);
    uword_t w;
    w.mode = m;
    w.nxt  = n;
    w.ctrl = ctrl_t'(c);
    return w;
  endfunction
endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
  import mseq_pkg::*;
(
  input  logic [UPC_W-1:0] addr_i,
  output uword_t           word_o
);
  // ctrl bits: alu_fn[9:7] flag_wr reg_wr mem_wr mem_rd ar_load pc_inc ir_load
  localparam logic [CTRL_W-1:0] C_NONE  = 10'b000_0000000;
  localparam logic [CTRL_W-1:0] C_FETCH = 10'b000_0000011;
  localparam logic [CTRL_W-1:0] C_IMM   = 10'b000_0001010;
  localparam logic [CTRL_W-1:0] C_WREG  = 10'b000_0100000;
  localparam logic [CTRL_W-1:0] C_ARLD  = 10'b000_0000100;
  localparam logic [CTRL_W-1:0] C_MRD   = 10'b000_0101000;
  localparam logic [CTRL_W-1:0] C_MWR   = 10'b000_0010000;
  localparam logic [CTRL_W-1:0] C_PCLD  = 10'b111_0000000;
  localparam logic [CTRL_W-1:0] C_SUB   = 10'b001_1100000;
  localparam logic [CTRL_W-1:0] C_ADD   = 10'b010_1100000;
  localparam logic [CTRL_W-1:0] C_AND   = 10'b011_1100000;
  localparam logic [CTRL_W-1:0] C_DEC   = 10'b100_1100000;
  localparam logic [CTRL_W-1:0] C_CLR   = 10'b101_1100000;
  localparam logic [CTRL_W-1:0] C_ROT   = 10'b110_1100000;
  localparam logic [CTRL_W-1:0] C_RRC   = 10'b110_1100001 & 10'b111_1111110 | 10'b000_1000000;

  always_comb begin
    word_o = mk(SEQ_JMP, FETCH_ADDR, C_NONE);
    case (addr_i)
      11'h000: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_NONE);
      11'h001: word_o = mk(SEQ_MAP,  MAP_BASE,   C_FETCH);
      // load immediate
      11'h600: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h601: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_WREG);
      // output port
      11'h620: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_WREG);
      // load from memory
      11'h640: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h641: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h642: word_o = mk(SEQ_INC,  '0,         C_ARLD);
      11'h643: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_MRD);
      // store to memory
      11'h660: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h661: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h662: word_o = mk(SEQ_INC,  '0,         C_ARLD);
      11'h663: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_MWR);
      // unconditional jump
      11'h680: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h681: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h682: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_PCLD);
      // jump on zero
      11'h6A0: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h6A1: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h6A2: word_o = mk(SEQ_TSTZ, 11'h6A4,    C_NONE);
      11'h6A4: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_NONE);
      11'h6A5: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_PCLD);
      // jump on carry
      11'h6C0: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h6C1: word_o = mk(SEQ_INC,  '0,         C_IMM);
      11'h6C2: word_o = mk(SEQ_TSTC, 11'h6C4,    C_NONE);
      11'h6C4: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_NONE);
      11'h6C5: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_PCLD);
      // stop: spin between two words
      11'h6E0: word_o = mk(SEQ_INC,  '0,         C_WREG);
      11'h6E1: word_o = mk(SEQ_JMP,  11'h6E0,    C_DEC);
      // two-operand ALU
      11'h700: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h701: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h702: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_SUB);
      11'h720: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h721: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h722: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_ADD);
      11'h740: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h741: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h742: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_AND);
      // one-operand ALU
      11'h760: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h761: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_DEC);
      11'h780: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h781: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_CLR);
      11'h7A0: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h7A1: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_ROT);
      11'h7C0: word_o = mk(SEQ_INC,  '0,         C_NONE);
      11'h7C1: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_RRC);
      // register move
      11'h7E0: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_WREG);
      default: word_o = mk(SEQ_JMP,  FETCH_ADDR, C_NONE);
    endcase
  end
endmodule

// File: rtl/mseq_next.sv
module mseq_next
  import mseq_pkg::*;
(
  input  seq_mode_e        mode_i,
  input  logic [UPC_W-1:0] nxt_i,
  input  logic [UPC_W-1:0] upc_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             zero_i,
  input  logic             carry_i,
  output logic [UPC_W-1:0] upc_d_o
);
  logic [UPC_W-1:0] entry;

  assign entry = {nxt_i[UPC_W-1 -: BASE_W], op_i, {SLOT_W{1'b0}}};

  always_comb begin
    case (mode_i)
      SEQ_INC:  upc_d_o = upc_i + UPC_W'(1);
      SEQ_JMP:  upc_d_o = nxt_i;
      SEQ_MAP:  upc_d_o = entry;
      SEQ_TSTZ: upc_d_o = {nxt_i[UPC_W-1:1], zero_i};
      SEQ_TSTC: upc_d_o = {nxt_i[UPC_W-1:1], carry_i};
      default:  upc_d_o = FETCH_ADDR;
    endcase
  end
endmodule

// File: rtl/mseq_upc.sv
module mseq_upc
  import mseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [UPC_W-1:0] upc_d_i,
  output logic [UPC_W-1:0] upc_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q_o <= IDLE_ADDR;
    else         upc_q_o <= upc_d_i;
  end
endmodule

// File: rtl/mseq_core.sv
module mseq_core
  import mseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   ir_op_i,
  input  logic              zero_i,
  input  logic              carry_i,
  output logic [WORD_W-1:0] uword_o,
  output logic [UPC_W-1:0]  upc_o
);
  uword_t           word;
  logic [UPC_W-1:0] upc_d;

  mseq_rom i_rom (
    .addr_i (upc_o),
    .word_o (word)
  );

  mseq_next i_next (
    .mode_i  (word.mode),
    .nxt_i   (word.nxt),
    .upc_i   (upc_o),
    .op_i    (ir_op_i),
    .zero_i  (zero_i),
    .carry_i (carry_i),
    .upc_d_o (upc_d)
  );

  mseq_upc i_upc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upc_d_i (upc_d),
    .upc_q_o (upc_o)
  );

  assign uword_o = word;

  p_idle_to_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == IDLE_ADDR) |=> (upc_o == FETCH_ADDR));

  p_entry_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == FETCH_ADDR) |=> (upc_o[SLOT_W-1:0] == '0 && upc_o[UPC_W-1 -: BASE_W] == MAP_BASE[UPC_W-1 -: BASE_W]
                               && upc_o[SLOT_W +: OP_W] == $past(ir_op_i)));

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word.mode == SEQ_INC) |=> (upc_o == $past(upc_o) + UPC_W'(1)));

  p_test_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word.mode == SEQ_TSTZ || word.mode == SEQ_TSTC) |=> (upc_o[UPC_W-1:1] == $past(word.nxt[UPC_W-1:1])));

  p_halt_loop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_o == 11'h6E1) |=> (upc_o == 11'h6E0));

  p_fetch_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (uword_o[0] == (upc_o == FETCH_ADDR)));
endmodule

// File: tb/test_mseq_core.sv
module test_mseq_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  ir_op = 4'h0;
  logic        zf = 1'b0;
  logic        cf = 1'b0;
  logic [23:0] uword_o;
  logic [10:0] upc_o;

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_upc = 0;
  int    cyc = 0;
  int    pi = 0;
  bit    cur_z, cur_c;
  bit    done = 0;
  string tag = "R1";

  localparam int NPROG = 18;
  int  prog_op [NPROG] = '{0, 1, 2, 3, 4, 5, 5, 6, 6, 8, 9, 10, 11, 12, 13, 14, 15, 7};
  bit  prog_z  [NPROG] = '{0, 1, 0, 1, 0, 0, 1, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  bit  prog_c  [NPROG] = '{1, 0, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0};

  always #2.5 clk_i = ~clk_i;

  mseq_core i_mseq_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ir_op_i (ir_op),
    .zero_i  (zf),
    .carry_i (cf),
    .uword_o (uword_o),
    .upc_o   (upc_o)
  );

  function automatic int slot_len(int k);
    case (k)
      0, 11, 12, 13, 14: return 2;
      1, 15:             return 1;
      2, 3:              return 4;
      default:           return 3;
    endcase
  endfunction

  function automatic int ref_next(int pc, int op, bit z, bit c);
    int k, o, base;
    if (pc == 0) return 1;
    if (pc == 1) return 'h600 + op * 32;
    k = (pc >> 5) & 15;
    o = pc & 31;
    base = 'h600 + k * 32;
    if (k == 5 || k == 6) begin
      if (o < 2) return pc + 1;
      if (o == 2) return base + 4 + ((k == 5) ? int'(z) : int'(c));
      return 1;
    end
    if (k == 7) return (o == 0) ? pc + 1 : base;
    return (o < slot_len(k) - 1) ? pc + 1 : 1;
  endfunction

  function automatic string tag_of(int pc);
    int k;
    if (pc == 0) return "R2";
    if (pc == 1) return "R3 R4";
    k = (pc >> 5) & 15;
    if (k == 5) return "R6";
    if (k == 6) return "R7";
    if (k == 7) return "R8";
    return "R5 R9";
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_upc <= 0;
      tag     <= "R1";
    end else begin
      tag     <= tag_of(exp_upc);
      exp_upc <= ref_next(exp_upc, int'(ir_op), zf, cf);
    end
  end

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    int k, o;
    chk(int'(upc_o) == exp_upc, tag, int'(upc_o), exp_upc);
    chk(uword_o[0] == (exp_upc == 1), "R10", int'(uword_o[0]), int'(exp_upc == 1));
    k = (exp_upc >> 5) & 15;
    o = exp_upc & 31;
    if (exp_upc == 1) begin
      if (pi < NPROG) begin
        ir_op = 4'(prog_op[pi]);
        cur_z = prog_z[pi];
        cur_c = prog_c[pi];
        pi++;
      end else begin
        ir_op = 4'h7;
      end
    end else begin
      ir_op = 4'(cyc) ^ 4'h9;  // R9 noise
    end
    if (exp_upc >= 'h600 && (k == 5 || k == 6) && o == 2) begin
      zf = cur_z;
      cf = cur_c;
    end else begin
      zf = cyc[0];
      cf = cyc[1];
    end
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk(upc_o == 11'h000, "R1", int'(upc_o), 0);
    chk(uword_o[0] == 1'b0, "R1", int'(uword_o[0]), 0);
    rst_ni = 1'b1;
    repeat (160) begin
      @(negedge clk_i);
      step();
    end
    chk(int'(upc_o) == 'h6E0 || int'(upc_o) == 'h6E1, "R8", int'(upc_o), 'h6E0);
    // asynchronous reset in mid-cycle
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    chk(upc_o == 11'h000, "R1", int'(upc_o), 0);
    chk(uword_o[0] == 1'b0, "R1", int'(uword_o[0]), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pi = 0;
    repeat (160) begin
      @(negedge clk_i);
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R5 act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule